// File: doc/BRIEF.md
# Interrupt Mask Register Unit

This block holds a 64-entry interrupt mask and gates 64 pending request lines with it. A set mask bit blocks its source. The gated vector and a single "something is active" flag leave the block from registers, so downstream priority logic sees them one clock after the request inputs.

Software reaches the mask over a small register bus in two ways. A full 32-bit word write replaces either the upper or the lower half of the mask. A byte-wide command sent to the set or the clear command offset changes a single mask bit chosen by a 6-bit index, or every bit at once when the all-bits flag in that byte is set. The command offsets are write-only. Any write that matches no offset and access size raises a one-cycle error pulse.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset every mask bit is 1, `masked_pend` is zero, `any_active` is 0 and `wr_err` is 0.
- R2: A word write (`wr_byte`=0) to offset 0x0C loads `wdata` into mask bits 31:0 and leaves bits 63:32 unchanged.
- R3: A word write to offset 0x08 loads `wdata` into mask bits 63:32 and leaves bits 31:0 unchanged.
- R4: A byte write (`wr_byte`=1) to offset 0x1C with `wdata[6]`=1 sets all 64 mask bits to 1.
- R5: A byte write to offset 0x1C with `wdata[6]`=0 sets only the mask bit whose index is `wdata[5:0]`.
- R6: A byte write to offset 0x1D with `wdata[6]`=1 clears all 64 mask bits to 0.
- R7: A byte write to offset 0x1D with `wdata[6]`=0 clears only the mask bit whose index is `wdata[5:0]`.
- R8: For byte commands, `wdata[7]` and `wdata[31:8]` have no effect on the mask.
- R9: A write with any other pairing of offset and access size leaves the mask unchanged and drives `wr_err` high for exactly the cycle after the write; valid writes and idle cycles leave `wr_err` low.
- R10: `rdata` is registered: one cycle after `addr` is presented it shows mask bits 63:32 for 0x08, mask bits 31:0 for 0x0C, and zero for every other offset, including 0x1C and 0x1D.
- R11: `masked_pend` equals `pend` AND NOT mask, registered one cycle after the inputs, and `any_active` is 1 in the same cycle exactly when `masked_pend` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_byte | input | 1 | 1 = byte command write, 0 = 32-bit word write |
| wdata | input | 32 | Write data; byte commands use bits 7:0 |
| rdata | output | 32 | Registered read data for `addr` |
| wr_err | output | 1 | One-cycle pulse after an undecoded write |
| pend | input | 64 | Raw interrupt request lines |
| masked_pend | output | 64 | Registered pending AND NOT mask |
| any_active | output | 1 | Registered OR of `masked_pend` |

## Verification
Every one of the 64 indices is sent through single-bit clear and set commands, each with and without junk in bit 7 and the upper data bits, and both mask halves are read after each command. This separates a wrong index decode, a bleed across the word boundary and a flag bit that is not ignored. All 256 offsets are written in both access sizes to tell decoded from undecoded pairs. Walking-one request patterns against an alternating mask, and all-ones requests against all-clear and all-set masks, separate the polarity of the gating and the any-active reduction from an off-by-one in the bit lanes.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int unsigned OFS_MASK_HI = 8'h08;
  localparam int unsigned OFS_MASK_LO = 8'h0C;
  localparam int unsigned OFS_BIT_SET = 8'h1C;
  localparam int unsigned OFS_BIT_CLR = 8'h1D;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WORD,
    OP_SET,
    OP_CLR,
    OP_BAD
  } op_e;
endpackage

// File: rtl/irqm_decode.sv
module irqm_decode
  import irqm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NWORDS = 2,
  localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              wr_byte,
  output op_e               op,
  output logic [WSEL_W-1:0] word_sel
);
  always_comb begin
    op       = OP_IDLE;
    word_sel = '0;
    if (wr_en) begin
      if (!wr_byte && addr == ADDR_W'(OFS_MASK_HI)) begin
        op       = OP_WORD;
        word_sel = WSEL_W'(1);
      end else if (!wr_byte && addr == ADDR_W'(OFS_MASK_LO)) begin
        op       = OP_WORD;
        word_sel = WSEL_W'(0);
      end else if (wr_byte && addr == ADDR_W'(OFS_BIT_SET)) begin
        op = OP_SET;
      end else if (wr_byte && addr == ADDR_W'(OFS_BIT_CLR)) begin
        op = OP_CLR;
      end else begin
        op = OP_BAD;
      end
    end
  end
endmodule

// File: rtl/irqm_mask_reg.sv
module irqm_mask_reg
  import irqm_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int DATA_W = 32,
  localparam int NWORDS = N_SRC / DATA_W,
  localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int IDX_W  = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic [WSEL_W-1:0] word_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_SRC-1:0]  mask
);
  logic [N_SRC-1:0] mask_nxt;
  logic [IDX_W-1:0] bit_idx;
  logic             all_flag;

  assign bit_idx  = wdata[IDX_W-1:0];
  assign all_flag = wdata[IDX_W];

  always_comb begin
    mask_nxt = mask;
    unique case (op)
      OP_WORD: begin
        for (int w = 0; w < NWORDS; w++) begin
          if (word_sel == WSEL_W'(w)) mask_nxt[w*DATA_W +: DATA_W] = wdata;
        end
      end
      OP_SET: begin
        if (all_flag) mask_nxt = '1;
        else          mask_nxt[bit_idx] = 1'b1;
      end
      OP_CLR: begin
        if (all_flag) mask_nxt = '0;
        else          mask_nxt[bit_idx] = 1'b0;
      end
      default: mask_nxt = mask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mask <= '1;
    else     mask <= mask_nxt;
  end
endmodule

// File: rtl/irqm_gate.sv
module irqm_gate #(
  parameter int N_SRC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] mask,
  output logic [N_SRC-1:0] masked_pend,
  output logic             any_active
);
  logic [N_SRC-1:0] gated;

  assign gated = pend & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      masked_pend <= '0;
      any_active  <= 1'b0;
    end else begin
      masked_pend <= gated;
      any_active  <= |gated;
    end
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irqm_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              wr_byte,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_err,
  input  logic [N_SRC-1:0]  pend,
  output logic [N_SRC-1:0]  masked_pend,
  output logic              any_active
);
  localparam int NWORDS = N_SRC / DATA_W;
  localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  op_e              op;
  logic [WSEL_W-1:0] word_sel;
  logic [N_SRC-1:0]  mask_q;

  irqm_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_dec (
    .addr(addr), .wr_en(wr_en), .wr_byte(wr_byte), .op(op), .word_sel(word_sel)
  );

  irqm_mask_reg #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_mask (
    .clk(clk), .rst(rst), .op(op), .word_sel(word_sel), .wdata(wdata), .mask(mask_q)
  );

  irqm_gate #(.N_SRC(N_SRC)) u_gate (
    .clk(clk), .rst(rst), .pend(pend), .mask(mask_q),
    .masked_pend(masked_pend), .any_active(any_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      wr_err <= 1'b0;
    end else begin
      wr_err <= (op == OP_BAD);
      if (addr == ADDR_W'(OFS_MASK_HI))      rdata <= mask_q[(NWORDS-1)*DATA_W +: DATA_W];
      else if (addr == ADDR_W'(OFS_MASK_LO)) rdata <= mask_q[DATA_W-1:0];
      else                                    rdata <= '0;
    end
  end
endmodule

// File: rtl/irq_mask_unit_chk.sv
module irq_mask_unit_chk
  import irqm_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              wr_byte,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              wr_err,
  input logic [N_SRC-1:0]  pend,
  input logic [N_SRC-1:0]  mask,
  input logic [N_SRC-1:0]  masked_pend,
  input logic              any_active
);
  localparam int HI = N_SRC - DATA_W;
  localparam int IW = $clog2(N_SRC);

  logic wr_lo, wr_hi, set_all, clr_all, valid_wr;
  assign wr_lo    = wr_en && !wr_byte && addr == ADDR_W'(OFS_MASK_LO);
  assign wr_hi    = wr_en && !wr_byte && addr == ADDR_W'(OFS_MASK_HI);
  assign set_all  = wr_en && wr_byte && addr == ADDR_W'(OFS_BIT_SET) && wdata[IW];
  assign clr_all  = wr_en && wr_byte && addr == ADDR_W'(OFS_BIT_CLR) && wdata[IW];
  assign valid_wr = wr_lo || wr_hi ||
                    (wr_en && wr_byte && (addr == ADDR_W'(OFS_BIT_SET) || addr == ADDR_W'(OFS_BIT_CLR)));

  a_r2_low_word: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> mask[DATA_W-1:0] == $past(wdata) && mask[N_SRC-1:DATA_W] == $past(mask[N_SRC-1:DATA_W]));

  a_r3_high_word: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> mask[N_SRC-1:HI] == $past(wdata) && mask[HI-1:0] == $past(mask[HI-1:0]));

  a_r4_set_all: assert property (@(posedge clk) disable iff (rst)
    set_all |=> &mask);

  a_r6_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> mask == '0);

  a_r9_bad_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !valid_wr) |=> wr_err && $stable(mask));

  a_r9_no_spurious_err: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !valid_wr) |=> !wr_err);

  a_r10_read_hi: assert property (@(posedge clk) disable iff (rst)
    addr == ADDR_W'(OFS_MASK_HI) |=> rdata == $past(mask[N_SRC-1:HI]));

  a_r11_gate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> masked_pend == ($past(pend) & ~$past(mask)));

  a_r11_any: assert property (@(posedge clk) disable iff (rst)
    any_active == (masked_pend != '0));
endmodule

bind irq_mask_unit irq_mask_unit_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_byte(wr_byte), .wdata(wdata),
  .rdata(rdata), .wr_err(wr_err), .pend(pend), .mask(mask_q),
  .masked_pend(masked_pend), .any_active(any_active)
);

// File: tb/irq_mask_unit_test.sv
`timescale 1ns/1ps
module irq_mask_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic        wr_byte = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wr_err;
  logic [63:0] pend = '0;
  logic [63:0] masked_pend;
  logic        any_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [63:0] model;

  always #4 clk = ~clk;

  irq_mask_unit uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_byte(wr_byte), .wdata(wdata),
    .rdata(rdata), .wr_err(wr_err), .pend(pend), .masked_pend(masked_pend), .any_active(any_active)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model of the mask, from the requirements
  function automatic logic [63:0] apply(input logic [63:0] m, input logic [7:0] a,
                                        input logic b, input logic [31:0] d, output logic bad);
    logic [63:0] r = m;
    bad = 1'b0;
    if (!b && a == 8'h0C)      r[31:0]  = d;
    else if (!b && a == 8'h08) r[63:32] = d;
    else if (b && a == 8'h1C)  begin if (d[6]) r = '1; else r[d[5:0]] = 1'b1; end
    else if (b && a == 8'h1D)  begin if (d[6]) r = '0; else r[d[5:0]] = 1'b0; end
    else bad = 1'b1;
    return r;
  endfunction

  task automatic wr(input string req, input logic [7:0] a, input logic b, input logic [31:0] d);
    logic bad;
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_byte = b; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model = apply(model, a, b, d, bad);
    check({req, " R9 err"}, {63'd0, wr_err}, {63'd0, bad});
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic check_mask(input string req);
    logic [31:0] hi, lo;
    rd(8'h08, hi);
    rd(8'h0C, lo);
    check({req, " R10 readback"}, {hi, lo}, model);
  endtask

  task automatic check_gate(input string req, input logic [63:0] p);
    @(negedge clk);
    pend = p;
    @(negedge clk);
    check({req, " R11 masked"}, masked_pend, p & ~model);
    check({req, " R11 any"}, {63'd0, any_active}, {63'd0, |(p & ~model)});
  endtask

  initial begin
    logic [31:0] d;
    model = '1;
    pend  = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 masked", masked_pend, 64'd0);
    check("R1 any", {63'd0, any_active}, 64'd0);
    check("R1 err", {63'd0, wr_err}, 64'd0);
    check_mask("R1 mask all ones");

    // R6 / R4: clear all then set all, bit 7 and upper bits junk (R8)
    wr("R6", 8'h1D, 1'b1, 32'hABCD_12C0);
    check_mask("R6 clear all");
    wr("R4", 8'h1C, 1'b1, 32'h0000_00C0);
    check_mask("R4 set all");

    // R7 / R5 single-bit sweep, with and without bit 7 junk (R8)
    for (int i = 0; i < 64; i++) begin
      wr("R7", 8'h1D, 1'b1, 32'h0000_0000 | i);
      check_mask("R7 single clear");
      wr("R8", 8'h1D, 1'b1, 32'hFFFF_FF00 | 32'h80 | i);
      check_mask("R8 clear junk ignored");
      wr("R5", 8'h1C, 1'b1, i);
      check_mask("R5 single set");
      wr("R8", 8'h1C, 1'b1, 32'h5A5A_5A00 | 32'h80 | i);
      check_mask("R8 set junk ignored");
      wr("R7", 8'h1D, 1'b1, i);
    end
    check_mask("R7 after sweep all clear");

    // R2 / R3 word writes
    wr("R3", 8'h08, 1'b0, 32'hDEAD_BEEF);
    check_mask("R3 high word");
    wr("R2", 8'h0C, 1'b0, 32'h1234_5678);
    check_mask("R2 low word");
    wr("R2", 8'h0C, 1'b0, 32'h8765_4321);
    check_mask("R2 high kept");
    wr("R3", 8'h08, 1'b0, 32'h0F0F_F0F0);
    check_mask("R3 low kept");

    // R10: command offsets and others read zero
    rd(8'h1C, d); check("R10 set offset reads zero", {32'd0, d}, 64'd0);
    rd(8'h1D, d); check("R10 clr offset reads zero", {32'd0, d}, 64'd0);
    rd(8'h00, d); check("R10 other offset reads zero", {32'd0, d}, 64'd0);

    // R9: every offset, both sizes
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 2; b++) begin
        wr("R9 sweep", a[7:0], b[0], {a[7:0], ~a[7:0], a[7:0], 8'h05 ^ a[7:0]});
      end
    end
    check_mask("R9 mask after sweep");

    // R11 gating patterns
    wr("R6", 8'h1D, 1'b1, 32'h40);
    check_gate("R11 all clear mask", '1);
    check_gate("R11 no pend", '0);
    wr("R4", 8'h1C, 1'b1, 32'h40);
    check_gate("R11 all set mask", '1);
    wr("R3", 8'h08, 1'b0, 32'h5555_5555);
    wr("R2", 8'h0C, 1'b0, 32'h5555_5555);
    for (int k = 0; k < 64; k++) check_gate("R11 walking one", 64'd1 << k);
    check_gate("R11 mixed", 64'hF0F0_1234_ABCD_9876);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule